// File: doc/BRIEF.md
# Framed Serial Command Decoder

This block is the slave side of a four-wire serial command port for a converter-style device. A host shifts fixed 32-bit frames in on `mosi` under one of two active-low chip-selects. Each frame holds an opcode byte, an argument byte, a check byte and a trailing zero byte. A frame whose check byte and trailer both pass is decoded. The result is a one-cycle control strobe, a register read or write, or a change to a write lock. A frame that fails is dropped and a sticky error flag is set.

The register file holds 32 bytes in two banks of 16. The lower bank, addresses 00h to 0Fh, is reached only through the first chip-select. The upper bank, addresses 10h to 1Fh, is reached only through the second. Each bank has its own write lock, which is set or cleared through that bank's chip-select. A register read, or a conversion-data read of the stub `conv_data` input, is answered in the first byte of the frame that follows.

The serial pins are oversampled in the `clk` domain, so SCLK must be slow against `clk`. Each half period of SCLK must last at least `SYNC_STAGES`+2 `clk` cycles.

Top module: `spi_cmd_decoder`

## Requirements
- R1: Frames are 32 bits, sampled MSB first on rising SCLK. With the first chip-select, a valid frame with opcode 06h, 08h, 0Ah, 12h, 16h or 17h gives exactly one single-cycle pulse on `pulse_reset`, `pulse_start`, `pulse_stop`, `pulse_read`, `pulse_ofs_cal` or `pulse_gain_cal` respectively. Opcode 00h gives no pulse.
- R2: Byte 3 must equal a CRC-8 with polynomial 07h and initial value FFh, taken over bytes 1 and 2 MSB first. On a mismatch the frame has no effect and `crc_error` is set. `crc_error` stays set until `rst_n` or a reset command clears it.
- R3: A frame whose byte 4 is not 00h is treated exactly like a CRC mismatch.
- R4: Byte 2 has no effect except in a register write.
- R5: The control and calibration opcodes act only when the first chip-select alone is low. Under the second chip-select they do nothing.
- R6: Opcode 40h+a writes byte 2 into register a. Opcode 20h+a returns register a in the top byte of the next frame shifted out on `miso`, with the other 24 bits zero. Any later frame returns zero.
- R7: Addresses 00h–0Fh are served only with the first chip-select and 10h–1Fh only with the second. A mismatched read returns zero, and a mismatched write changes nothing.
- R8: F2h locks and F5h unlocks writes to the bank of the active chip-select. A write to a locked bank changes nothing. The other bank is unaffected.
- R9: The reset command restores every register to 00h and clears both locks and `crc_error`.
- R10: Opcode 12h returns the `conv_data` value in the top byte of the next frame.
- R11: Opcodes outside the legal set have no effect, as do frames clocked with both chip-selects low.
- R12: Raising the chip-select mid-frame discards the partial frame. The next full frame decodes normally.
- R13: `miso` changes after falling SCLK and is 0 whenever neither chip-select alone is active.
- R14: After `rst_n` all pulses, `crc_error` and `miso` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host |
| cs1_n | input | 1 | First chip-select, lower bank and control commands |
| cs2_n | input | 1 | Second chip-select, upper bank |
| mosi | input | 1 | Serial data in |
| conv_data | input | 8 | Stub conversion result returned by read-data |
| miso | output | 1 | Serial data out |
| pulse_reset | output | 1 | Reset command strobe |
| pulse_start | output | 1 | Start-conversion strobe |
| pulse_stop | output | 1 | Stop-conversion strobe |
| pulse_read | output | 1 | Read-data strobe |
| pulse_ofs_cal | output | 1 | Offset calibration strobe |
| pulse_gain_cal | output | 1 | Gain calibration strobe |
| crc_error | output | 1 | Sticky frame check failure flag |

## Verification
The bench sends each control opcode under both chip-selects. A decoder that ignores the select would pulse under the wrong one. It pairs register reads and writes across the banks, so that a decoder which checks the address but not the select would leak writes into the other bank. It locks one bank and writes to both: a global lock would block the free bank, and a lock that is never checked would let the locked write through. It also sends frames with a flipped check bit, a nonzero trailer, both selects low, and an aborted partial frame. A decoder that acted on any of them would produce a stray strobe or set the error flag at the wrong time.

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder #(
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] REG_INIT = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs1_n,
  input  logic       cs2_n,
  input  logic       mosi,
  input  logic [7:0] conv_data,
  output logic       miso,
  output logic       pulse_reset,
  output logic       pulse_start,
  output logic       pulse_stop,
  output logic       pulse_read,
  output logic       pulse_ofs_cal,
  output logic       pulse_gain_cal,
  output logic       crc_error
);
  localparam int AW   = 5;
  localparam int NREG = 1 << AW;
  localparam int FW   = 32;
  localparam int CW   = $clog2(FW);

  function automatic logic [7:0] crc8(input logic [15:0] d);
    logic [7:0] c;
    c = 8'hFF;
    for (int i = 15; i >= 0; i--) begin
      if (c[7] ^ d[i]) c = {c[6:0], 1'b0} ^ 8'h07;
      else             c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

  logic [SYNC_STAGES:0]   sclk_p;
  logic [SYNC_STAGES-1:0] cs1_p, cs2_p, mosi_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs1_p  <= '1;
      cs2_p  <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC_STAGES-1:0], sclk};
      cs1_p  <= {cs1_p[SYNC_STAGES-2:0], cs1_n};
      cs2_p  <= {cs2_p[SYNC_STAGES-2:0], cs2_n};
      mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi};
    end
  end

  wire sclk_s = sclk_p[SYNC_STAGES-1];
  wire rise   = sclk_s & ~sclk_p[SYNC_STAGES];
  wire fall   = ~sclk_s & sclk_p[SYNC_STAGES];
  wire mosi_s = mosi_p[SYNC_STAGES-1];
  wire sel_a  = ~cs1_p[SYNC_STAGES-1] & cs2_p[SYNC_STAGES-1];
  wire sel_b  = cs1_p[SYNC_STAGES-1] & ~cs2_p[SYNC_STAGES-1];
  wire sel    = sel_a | sel_b;

  logic [CW-1:0]             bit_cnt;
  logic                      bank_q;
  logic [FW-2:0]             rx;
  logic [FW-1:0]             tx_sr;
  logic [1:0]                lock;
  logic [NREG-1:0][7:0]      regs;

  wire abort     = ~sel | ((bit_cnt != '0) & (sel_b != bank_q));
  wire frame_end = ~abort & rise & (bit_cnt == CW'(FW - 1));

  wire [FW-1:0]   frame    = {rx, mosi_s};
  wire [7:0]      op       = frame[31:24];
  wire [7:0]      arg      = frame[23:16];
  wire            frame_ok = (frame[15:8] == crc8(frame[31:16])) && (frame[7:0] == 8'h00);
  wire [AW-1:0]   addr     = op[AW-1:0];
  wire            bank_hit = (addr[AW-1] == sel_b);
  wire            is_rd    = (op[7:5] == 3'b001);
  wire            is_wr    = (op[7:5] == 3'b010);

  assign miso = sel & tx_sr[FW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt        <= '0;
      bank_q         <= 1'b0;
      rx             <= '0;
      tx_sr          <= '0;
      lock           <= '0;
      regs           <= {NREG{REG_INIT}};
      crc_error      <= 1'b0;
      pulse_reset    <= 1'b0;
      pulse_start    <= 1'b0;
      pulse_stop     <= 1'b0;
      pulse_read     <= 1'b0;
      pulse_ofs_cal  <= 1'b0;
      pulse_gain_cal <= 1'b0;
    end else begin
      pulse_reset    <= 1'b0;
      pulse_start    <= 1'b0;
      pulse_stop     <= 1'b0;
      pulse_read     <= 1'b0;
      pulse_ofs_cal  <= 1'b0;
      pulse_gain_cal <= 1'b0;
      if (abort) begin
        if (bit_cnt != '0) tx_sr <= '0;
        bit_cnt <= '0;
      end else if (rise) begin
        if (bit_cnt == '0) bank_q <= sel_b;
        rx      <= {rx[FW-3:0], mosi_s};
        bit_cnt <= bit_cnt + 1'b1;
      end else if (fall && bit_cnt != '0) begin
        tx_sr <= {tx_sr[FW-2:0], 1'b0};
      end

      if (frame_end) begin
        tx_sr <= '0;
        if (!frame_ok) begin
          crc_error <= 1'b1;
        end else if (is_rd) begin
          if (bank_hit) tx_sr <= {regs[addr], 24'h0};
        end else if (is_wr) begin
          if (bank_hit && !lock[sel_b]) regs[addr] <= arg;
        end else begin
          case (op)
            8'hF2: lock[sel_b] <= 1'b1;
            8'hF5: lock[sel_b] <= 1'b0;
            8'h06: if (sel_a) begin
              regs        <= {NREG{REG_INIT}};
              lock        <= '0;
              crc_error   <= 1'b0;
              pulse_reset <= 1'b1;
            end
            8'h08: if (sel_a) pulse_start <= 1'b1;
            8'h0A: if (sel_a) pulse_stop <= 1'b1;
            8'h12: if (sel_a) begin
              pulse_read <= 1'b1;
              tx_sr      <= {conv_data, 24'h0};
            end
            8'h16: if (sel_a) pulse_ofs_cal <= 1'b1;
            8'h17: if (sel_a) pulse_gain_cal <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

module spi_cmd_decoder_chk #(
  parameter int NREG = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [5:0]        pulses,
  input logic              pulse_reset,
  input logic              crc_error,
  input logic              frame_end,
  input logic              sel_a,
  input logic [1:0]        lock,
  input logic [NREG*8-1:0] regs
);
  localparam int HB = NREG * 4;

  assert_onehot_pulses_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulses));

  assert_single_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulses) |=> !(|pulses));

  assert_pulse_needs_first_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulses) |-> $past(frame_end && sel_a));

  assert_error_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    crc_error |=> (crc_error || pulse_reset));

  assert_low_bank_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock[0] |=> ($stable(regs[HB-1:0]) || pulse_reset));

  assert_high_bank_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock[1] |=> ($stable(regs[NREG*8-1:HB]) || pulse_reset));
endmodule

bind spi_cmd_decoder spi_cmd_decoder_chk #(.NREG(NREG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pulses      ({pulse_reset, pulse_start, pulse_stop, pulse_read, pulse_ofs_cal, pulse_gain_cal}),
  .pulse_reset (pulse_reset),
  .crc_error   (crc_error),
  .frame_end   (frame_end),
  .sel_a       (sel_a),
  .lock        (lock),
  .regs        (regs)
);

// File: tb/spi_cmd_decoder_bench.sv
module spi_cmd_decoder_bench;
  localparam int HALF = 6;
  localparam int NV   = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs1_n = 1'b1, cs2_n = 1'b1, mosi = 1'b0;
  logic [7:0] conv_data = 8'h00;
  logic miso, pulse_reset, pulse_start, pulse_stop, pulse_read, pulse_ofs_cal, pulse_gain_cal, crc_error;

  int checks = 0, errors = 0;
  int cnt [6];

  always #10 clk = ~clk;

  spi_cmd_decoder u_spi_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs1_n(cs1_n), .cs2_n(cs2_n), .mosi(mosi),
    .conv_data(conv_data), .miso(miso), .pulse_reset(pulse_reset), .pulse_start(pulse_start),
    .pulse_stop(pulse_stop), .pulse_read(pulse_read), .pulse_ofs_cal(pulse_ofs_cal),
    .pulse_gain_cal(pulse_gain_cal), .crc_error(crc_error)
  );

  wire [5:0] pv = {pulse_reset, pulse_start, pulse_stop, pulse_read, pulse_ofs_cal, pulse_gain_cal};

  always @(negedge clk)
    for (int k = 0; k < 6; k++) if (pv[k]) cnt[k]++;

  // {use second select, opcode, argument, expected pulses {reset,start,stop,read,ofs,gain}}
  localparam logic [NV-1:0][22:0] VEC = {
    {1'b0, 8'h00, 8'h00, 6'b000000},
    {1'b0, 8'h06, 8'h00, 6'b100000},
    {1'b0, 8'h08, 8'h00, 6'b010000},
    {1'b0, 8'h0A, 8'h00, 6'b001000},
    {1'b0, 8'h12, 8'h00, 6'b000100},
    {1'b0, 8'h16, 8'h00, 6'b000010},
    {1'b0, 8'h17, 8'h00, 6'b000001},
    {1'b0, 8'h08, 8'hA5, 6'b010000},
    {1'b1, 8'h08, 8'h00, 6'b000000},
    {1'b1, 8'h16, 8'h00, 6'b000000},
    {1'b1, 8'h06, 8'h00, 6'b000000},
    {1'b0, 8'h01, 8'h00, 6'b000000},
    {1'b0, 8'hFF, 8'h3C, 6'b000000}
  };

  function automatic logic [7:0] ref_crc(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    logic [15:0] m;
    r = 8'hFF;
    m = {a, b};
    for (int i = 0; i < 16; i++) begin
      logic top;
      top = r[7] ^ m[15 - i];
      r = r << 1;
      if (top) r = r ^ 8'b0000_0111;
    end
    return r;
  endfunction

  function automatic logic [31:0] mk(input logic [7:0] op, input logic [7:0] arg);
    return {op, arg, ref_crc(op, arg), 8'h00};
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic xfer(input logic use_b, input logic both, input logic [31:0] w,
                      input int nbits, output logic [31:0] rxw);
    rxw = '0;
    cs1_n = !(both || !use_b);
    cs2_n = !(both || use_b);
    wclk(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = w[31 - i];
      wclk(HALF);
      rxw[31 - i] = miso;
      sclk = 1'b1;
      wclk(HALF);
      sclk = 1'b0;
    end
    wclk(HALF);
    cs1_n = 1'b1;
    cs2_n = 1'b1;
    wclk(HALF);
  endtask

  task automatic cmd(input logic use_b, input logic [7:0] op, input logic [7:0] arg);
    logic [31:0] d;
    xfer(use_b, 1'b0, mk(op, arg), 32, d);
  endtask

  task automatic rd(input logic use_b, input logic [7:0] a, output logic [31:0] r);
    logic [31:0] d;
    xfer(use_b, 1'b0, mk(8'h20 + a, 8'h00), 32, d);
    xfer(use_b, 1'b0, mk(8'h00, 8'h00), 32, r);
  endtask

  function automatic logic [5:0] delta(input int b [6]);
    logic [5:0] m;
    for (int k = 0; k < 6; k++) m[k] = (cnt[k] - b[k]) != 0;
    return m;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int b [6];
    logic [31:0] r;
    for (int k = 0; k < 6; k++) cnt[k] = 0;
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    check("R14 reset state", {29'h0, miso, crc_error, |pv}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      b = cnt;
      cmd(VEC[NV-1-v][22], VEC[NV-1-v][21:14], VEC[NV-1-v][13:6]);
      check("R1/R4/R5/R11 table", {26'h0, delta(b)}, {26'h0, VEC[NV-1-v][5:0]});
    end

    // R6 write and read back, response only in the next frame
    cmd(1'b0, 8'h43, 8'h5A);
    rd(1'b0, 8'h03, r);
    check("R6 read back", r, 32'h5A00_0000);
    xfer(1'b0, 1'b0, mk(8'h00, 8'h00), 32, r);
    check("R6 stale response", r, 32'h0);

    // R7 bank selection
    cmd(1'b1, 8'h53, 8'hC3);
    rd(1'b1, 8'h13, r);
    check("R7 upper bank write", r, 32'hC300_0000);
    cmd(1'b0, 8'h53, 8'h11);
    rd(1'b1, 8'h13, r);
    check("R7 upper write via first select ignored", r, 32'hC300_0000);
    rd(1'b1, 8'h03, r);
    check("R7 lower read via second select", r, 32'h0);
    cmd(1'b1, 8'h44, 8'h99);
    rd(1'b0, 8'h04, r);
    check("R7 lower write via second select ignored", r, 32'h0);

    // R8 per-bank locks
    cmd(1'b0, 8'hF2, 8'h00);
    cmd(1'b0, 8'h43, 8'h11);
    rd(1'b0, 8'h03, r);
    check("R8 locked lower write", r, 32'h5A00_0000);
    cmd(1'b1, 8'h53, 8'h77);
    rd(1'b1, 8'h13, r);
    check("R8 upper bank still open", r, 32'h7700_0000);
    cmd(1'b0, 8'hF5, 8'h00);
    cmd(1'b0, 8'h43, 8'h22);
    rd(1'b0, 8'h03, r);
    check("R8 unlocked write", r, 32'h2200_0000);
    cmd(1'b1, 8'hF2, 8'h00);
    cmd(1'b1, 8'h53, 8'h88);
    rd(1'b1, 8'h13, r);
    check("R8 locked upper write", r, 32'h7700_0000);

    // R9 reset command
    cmd(1'b0, 8'h06, 8'h00);
    rd(1'b0, 8'h03, r);
    check("R9 lower restored", r, 32'h0);
    cmd(1'b1, 8'h53, 8'h44);
    rd(1'b1, 8'h13, r);
    check("R9 lock cleared", r, 32'h4400_0000);

    // R2 CRC failure and stickiness
    b = cnt;
    xfer(1'b0, 1'b0, mk(8'h08, 8'h00) ^ 32'h0000_0100, 32, r);
    check("R2 bad check byte no pulse", {26'h0, delta(b)}, 32'h0);
    check("R2 error flag set", {31'h0, crc_error}, 32'h1);
    b = cnt;
    cmd(1'b0, 8'h08, 8'h00);
    check("R2 good frame after error", {26'h0, delta(b)}, 32'h10);
    check("R2 flag sticky", {31'h0, crc_error}, 32'h1);
    cmd(1'b0, 8'h06, 8'h00);
    check("R2 flag cleared by reset command", {31'h0, crc_error}, 32'h0);
    xfer(1'b0, 1'b0, mk(8'h41, 8'h66) ^ 32'h0080_0000, 32, r);
    rd(1'b0, 8'h01, r);
    check("R2 write with bad check dropped", r, 32'h0);
    cmd(1'b0, 8'h06, 8'h00);

    // R3 nonzero trailer
    b = cnt;
    xfer(1'b0, 1'b0, mk(8'h0A, 8'h00) | 32'h0000_0001, 32, r);
    check("R3 trailer no pulse", {26'h0, delta(b)}, 32'h0);
    check("R3 trailer sets flag", {31'h0, crc_error}, 32'h1);
    cmd(1'b0, 8'h06, 8'h00);

    // R10 read data
    conv_data = 8'h9C;
    xfer(1'b0, 1'b0, mk(8'h12, 8'h00), 32, r);
    xfer(1'b0, 1'b0, mk(8'h00, 8'h00), 32, r);
    check("R10 conversion byte returned", r, 32'h9C00_0000);

    // R13 miso idle while a response is pending
    cmd(1'b0, 8'h12, 8'h00);
    check("R13 miso low when deselected", {31'h0, miso}, 32'h0);
    xfer(1'b0, 1'b0, mk(8'h00, 8'h00), 32, r);
    check("R13 response after deselect", r, 32'h9C00_0000);

    // R12 aborted partial frame
    b = cnt;
    xfer(1'b0, 1'b0, mk(8'h08, 8'h00), 13, r);
    cmd(1'b0, 8'h0A, 8'h00);
    check("R12 only the full frame acts", {26'h0, delta(b)}, 32'h08);
    check("R12 no error after abort", {31'h0, crc_error}, 32'h0);

    // R11 both selects low
    b = cnt;
    xfer(1'b0, 1'b1, mk(8'h08, 8'h00), 32, r);
    check("R11 both selects ignored", {26'h0, delta(b)}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule